// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one channel of a programmable interval timer. It holds a 16-bit down counter that moves one step for each cycle in which the count-enable tick is high. It drives a single output waveform, and the shape of that waveform depends on one of six operating modes. A load strobe captures three things at once: the mode, a binary-or-decimal select, and the initial count. Until the next strobe, the channel runs from those captured values. A gate input works in one of two ways, depending on the mode. In some modes its level pauses and resumes counting. In the others, a rising edge on the gate starts the count again from the initial value.

The counter can count in plain binary or in packed decimal, with four digits of four bits each. In both cases an initial count of zero means the largest possible count. In the one-shot and strobe modes the counter does not stop when it reaches zero. It rolls over to the all-ones or all-nines pattern and keeps going. The two periodic modes reload the initial count at the end of each period, giving a rate pulse or a square wave. The present count is available at all times, so that latch logic outside the block can sample it.

Top module: `interval_counter_chan`

## Requirements
- R1: After reset, out_o is 0 and count_o is 0. Before the first load strobe, ticks and gate activity leave both unchanged.
- R2: An initial count of 0 acts as 65536 ticks in binary counting and 10000 ticks in decimal counting (bcd_i=1).
- R3: In modes 2 and 3, the tick that would take the count to zero instead reloads the initial count, so count_o runs N, N-1, ..., 1 and repeats.
- R4: In mode 0, out_o is 0 after the load. It goes to 1 on the Nth counted tick and stays at 1 until the next load.
- R5: In mode 1, out_o is 0 while the count runs and 1 from the Nth counted tick onward. A gate rising edge drops it back to 0 and starts a new count.
- R6: In mode 2, out_o is 1 after every counted tick that completes a period, and 0 after the next counted tick.
- R7: In mode 3, out_o is 1 during the first (N+1)/2 ticks of every period and 0 during the rest.
- R8: In modes 4 and 5, out_o is 1 only between the Nth counted tick and the next counted tick, once per start.
- R9: In modes 0 and 4, a tick while gate_i is 0 is not counted.
- R10: In modes 1, 2, 3 and 5, a gate rising edge makes count_o equal the initial count on the next cycle, and counting resumes from there. This takes priority over a tick in the same cycle.
- R11: In modes 0, 1, 4 and 5, a counted tick at count 0 gives 0xFFFF in binary and 0x9999 in decimal.
- R12: In decimal counting, each 4-bit digit counts down from 0 to 9 and borrows from the digit above it, so every digit stays in the range 0 to 9.
- R13: mode_i codes 6 and 7 behave as modes 2 and 3. The mode, the count select and the value are taken only when load_i is 1.
- R14: A load strobe shows the initial count on count_o on the next cycle. Each counted tick updates count_o and out_o on the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en_i | input | 1 | Count-enable tick, one count step per high cycle |
| gate_i | input | 1 | Gate: a level enable or a restart trigger, depending on the mode |
| mode_i | input | 3 | Operating mode, captured at load |
| bcd_i | input | 1 | 1 selects four-digit decimal counting, captured at load |
| load_i | input | 1 | Load strobe for the mode, the count select and the initial count |
| init_i | input | 16 | Initial count; 0 means the maximum count |
| out_o | output | 1 | Mode-dependent output waveform |
| count_o | output | 16 | Present count, binary or packed decimal |

## Verification
A wrong reload or borrow appears on count_o on the cycle after the tick that caused it. In decimal counting a bad borrow also shows up as a digit above 9. A wrong period or terminal decision in the output logic shows on out_o at the first terminal tick, which is N counted ticks after the start. With the maximum count, that is 65536 or 10000 ticks later. For this reason the full-count cases are run to their end. An edge detector that misses a gate edge leaves count_o counting on from its old value instead of the initial count on the very next cycle. A gate enable that leaks through shows as count_o changing while gate_i is low.

// File: rtl/ic_pkg.sv
`timescale 1ns/1ps
package ic_pkg;

  typedef enum logic [2:0] {
    MODE_TERM_INT    = 3'd0,
    MODE_RETRIG_SHOT = 3'd1,
    MODE_RATE        = 3'd2,
    MODE_SQUARE      = 3'd3,
    MODE_SW_STROBE   = 3'd4,
    MODE_HW_STROBE   = 3'd5
  } ic_mode_e;

  // Codes 6 and 7 fold onto the two periodic modes.
  function automatic ic_mode_e fold_mode(input logic [2:0] raw);
    logic [2:0] f;
    f = (raw > 3'd5) ? (raw - 3'd4) : raw;
    return ic_mode_e'(f);
  endfunction

  function automatic logic is_periodic(input ic_mode_e m);
    return (m == MODE_RATE) || (m == MODE_SQUARE);
  endfunction

  function automatic logic is_retrig(input ic_mode_e m);
    return (m == MODE_RETRIG_SHOT) || (m == MODE_RATE) ||
           (m == MODE_SQUARE) || (m == MODE_HW_STROBE);
  endfunction

  function automatic logic is_level_gated(input ic_mode_e m);
    return (m == MODE_TERM_INT) || (m == MODE_SW_STROBE);
  endfunction

  function automatic int unsigned pow10(input int unsigned n);
    int unsigned r;
    r = 1;
    for (int unsigned i = 0; i < n; i++) r = r * 10;
    return r;
  endfunction

endpackage

// File: rtl/ic_dec_unit.sv
`timescale 1ns/1ps
// One-step decrement, binary or packed decimal, without the full-count bit.
module ic_dec_unit #(
  parameter int W = 16
) (
  input  logic [W-1:0] val_i,
  input  logic         bcd_i,
  output logic [W-1:0] res_o
);
  localparam int D = W / 4;

  logic [D-1:0] borrow;
  logic [W-1:0] bcd_res;
  logic [W-1:0] bin_res;

  assign borrow[0] = 1'b1;

  for (genvar i = 0; i < D; i++) begin : g_digit
    logic [3:0] dig;
    assign dig = val_i[4*i +: 4];
    assign bcd_res[4*i +: 4] = !borrow[i] ? dig :
                               ((dig == 4'd0) ? 4'd9 : (dig - 4'd1));
    if (i < D - 1) begin : g_chain
      assign borrow[i+1] = borrow[i] & (dig == 4'd0);
    end
  end

  assign bin_res = val_i - {{(W-1){1'b0}}, 1'b1};
  assign res_o   = bcd_i ? bcd_res : bin_res;

endmodule

// File: rtl/ic_bcd_to_bin.sv
`timescale 1ns/1ps
// Packed-decimal to binary weight, used once per load for the half period.
module ic_bcd_to_bin #(
  parameter int W = 16
) (
  input  logic [W-1:0] bcd_i,
  output logic [W:0]   bin_o
);
  localparam int D  = W / 4;
  localparam int CW = W + 1;

  logic [CW-1:0] psum [D+1];

  assign psum[0] = '0;

  for (genvar i = 0; i < D; i++) begin : g_acc
    localparam int unsigned WT = ic_pkg::pow10(i);
    assign psum[i+1] = psum[i] + CW'(bcd_i[4*i +: 4]) * CW'(WT);
  end

  assign bin_o = psum[D];

endmodule

// File: rtl/ic_edge_detect.sv
`timescale 1ns/1ps
module ic_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (rst) sig_q <= 1'b0;
    else     sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;

endmodule

// File: rtl/ic_out_shaper.sv
`timescale 1ns/1ps
// Registered output waveform, decided from the next counter state.
module ic_out_shaper
  import ic_pkg::*;
#(
  parameter int PW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  ic_mode_e      mode_i,
  input  logic          start_i,
  input  logic          evt_i,
  input  logic          term_i,
  input  logic [PW-1:0] ph_next_i,
  input  logic [PW-1:0] half_i,
  output logic          out_o
);
  logic out_q;
  logic fired_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= 1'b0;
      fired_q <= 1'b0;
    end else if (start_i) begin
      fired_q <= 1'b0;
      out_q   <= (mode_i == MODE_SQUARE);
    end else if (evt_i) begin
      case (mode_i)
        MODE_TERM_INT, MODE_RETRIG_SHOT: begin
          if (term_i) out_q <= 1'b1;
        end
        MODE_RATE:   out_q <= term_i;
        MODE_SQUARE: out_q <= (ph_next_i < half_i);
        default: begin
          out_q <= term_i & ~fired_q;
          if (term_i) fired_q <= 1'b1;
        end
      endcase
    end
  end

  assign out_o = out_q;

  // R4: once high in the terminal-level modes, out stays high until a new start.
  assert_level_hold_R4: assert property (@(posedge clk) disable iff (rst)
    ((mode_i == MODE_TERM_INT || mode_i == MODE_RETRIG_SHOT) && out_q && !start_i)
      |=> out_q);

  // R6: the rate pulse lasts one counted tick unless the period is a single tick.
  assert_rate_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_RATE && out_q && evt_i && !term_i && !start_i) |=> !out_q);

  // R7: every square-wave period begins in the high half.
  assert_square_start_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_SQUARE && evt_i && !start_i && ph_next_i == '0) |=> out_q);

  // R8: a strobe is dropped on the next counted tick.
  assert_strobe_once_R8: assert property (@(posedge clk) disable iff (rst)
    ((mode_i == MODE_SW_STROBE || mode_i == MODE_HW_STROBE) && out_q && evt_i && !start_i)
      |=> !out_q);

endmodule

// File: rtl/interval_counter_chan.sv
`timescale 1ns/1ps
module interval_counter_chan
  import ic_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_en_i,
  input  logic         gate_i,
  input  logic [2:0]   mode_i,
  input  logic         bcd_i,
  input  logic         load_i,
  input  logic [W-1:0] init_i,
  output logic         out_o,
  output logic [W-1:0] count_o
);
  localparam int CW = W + 1;
  localparam int D  = W / 4;
  localparam logic [CW-1:0] FULL_CODE = {1'b1, {W{1'b0}}};
  localparam int unsigned   DEC_FULL  = pow10(D);

  ic_mode_e      mode_q, mode_ld, mode_sel;
  logic          bcd_q, armed_q;
  logic [CW-1:0] n_q, c_q, half_q, ph_q;
  logic [CW-1:0] load_n, load_nbin, load_half, init_bin, ph_next;
  logic [CW:0]   nbin_inc;
  logic [W-1:0]  dec_res;
  logic          rise, restart, evt, term, reload;

  assign mode_ld  = fold_mode(mode_i);
  assign mode_sel = load_i ? mode_ld : mode_q;

  ic_bcd_to_bin #(.W(W)) u_conv (
    .bcd_i (init_i),
    .bin_o (init_bin)
  );

  ic_dec_unit #(.W(W)) u_dec (
    .val_i (c_q[W-1:0]),
    .bcd_i (bcd_q),
    .res_o (dec_res)
  );

  ic_edge_detect u_gate (
    .clk    (clk),
    .rst    (rst),
    .sig_i  (gate_i),
    .rise_o (rise)
  );

  assign load_n    = (init_i == '0) ? FULL_CODE : {1'b0, init_i};
  assign load_nbin = (init_i == '0) ? (bcd_i ? CW'(DEC_FULL) : FULL_CODE)
                                    : (bcd_i ? init_bin : {1'b0, init_i});
  assign nbin_inc  = {1'b0, load_nbin} + (CW+1)'(1);
  assign load_half = nbin_inc[CW:1];

  assign term    = (c_q == CW'(1));
  assign restart = armed_q & ~load_i & rise & is_retrig(mode_q);
  assign evt     = armed_q & ~load_i & ~restart & tick_en_i &
                   (gate_i | ~is_level_gated(mode_q));
  assign reload  = evt & term & is_periodic(mode_q);
  assign ph_next = reload ? '0 : (ph_q + CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      mode_q  <= MODE_TERM_INT;
      bcd_q   <= 1'b0;
      n_q     <= '0;
      half_q  <= '0;
      c_q     <= '0;
      ph_q    <= '0;
    end else if (load_i) begin
      armed_q <= 1'b1;
      mode_q  <= mode_ld;
      bcd_q   <= bcd_i;
      n_q     <= load_n;
      half_q  <= load_half;
      c_q     <= load_n;
      ph_q    <= '0;
    end else if (restart) begin
      c_q     <= n_q;
      ph_q    <= '0;
    end else if (evt) begin
      c_q     <= reload ? n_q : {1'b0, dec_res};
      ph_q    <= ph_next;
    end
  end

  ic_out_shaper #(.PW(CW)) u_out (
    .clk       (clk),
    .rst       (rst),
    .mode_i    (mode_sel),
    .start_i   (load_i | restart),
    .evt_i     (evt),
    .term_i    (term),
    .ph_next_i (ph_next),
    .half_i    (half_q),
    .out_o     (out_o)
  );

  assign count_o = c_q[W-1:0];

  // R1: nothing moves before the first load.
  assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !armed_q |-> (c_q == '0 && !out_o));

  // R3: periodic modes never sit at zero.
  assert_reload_R3: assert property (@(posedge clk) disable iff (rst)
    (armed_q && is_periodic(mode_q)) |-> (c_q != '0));

  // R9: a low gate freezes the count in the level-gated modes.
  assert_gate_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (armed_q && is_level_gated(mode_q) && !gate_i && !load_i) |=> $stable(c_q));

  // R10: a retrigger brings back the initial count.
  assert_restart_R10: assert property (@(posedge clk) disable iff (rst)
    restart |=> (c_q == $past(n_q)));

  // R12: decimal digits stay in range.
  for (genvar k = 0; k < D; k++) begin : g_bcd_chk
    assert_digit_R12: assert property (@(posedge clk) disable iff (rst)
      (armed_q && bcd_q) |-> (c_q[4*k +: 4] <= 4'd9));
  end

endmodule

// File: tb/interval_counter_chan_tb.sv
`timescale 1ns/1ps
module interval_counter_chan_tb;
  localparam int W = 16;
  localparam int WD_LIMIT = 150000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick_en_i = 1'b0;
  logic         gate_i = 1'b0;
  logic [2:0]   mode_i = 3'd0;
  logic         bcd_i = 1'b0;
  logic         load_i = 1'b0;
  logic [W-1:0] init_i = '0;
  logic         out_o;
  logic [W-1:0] count_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // model state: elapsed ticks since the last start
  int mN = 0, md = 0, mmode = 0;
  bit mbcd = 0, marmed = 0, gprev = 0;

  always #2.5 clk = ~clk;

  interval_counter_chan #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .tick_en_i(tick_en_i), .gate_i(gate_i),
    .mode_i(mode_i), .bcd_i(bcd_i), .load_i(load_i), .init_i(init_i),
    .out_o(out_o), .count_o(count_o)
  );

  function automatic int to_bcd(input int v);
    int r, x;
    r = 0; x = v;
    for (int i = 0; i < 4; i++) begin
      r = r | ((x % 10) << (4*i));
      x = x / 10;
    end
    return r;
  endfunction

  function automatic int from_bcd(input int v);
    int r, wt;
    r = 0; wt = 1;
    for (int i = 0; i < 4; i++) begin
      r = r + ((v >> (4*i)) & 15) * wt;
      wt = wt * 10;
    end
    return r;
  endfunction

  function automatic int fold(input int m);
    return (m > 5) ? m - 4 : m;
  endfunction

  function automatic int exp_count();
    int mm, v;
    if (!marmed) return 0;
    mm = mbcd ? 10000 : 65536;
    if (mmode == 2 || mmode == 3) v = (mN - (md % mN)) % mm;
    else v = (((mN - md) % mm) + mm) % mm;
    return mbcd ? to_bcd(v) : v;
  endfunction

  function automatic bit exp_out();
    if (!marmed) return 1'b0;
    case (mmode)
      0, 1:    return md >= mN;
      2:       return (md > 0) && (md % mN == 0);
      3:       return (md % mN) < ((mN + 1) / 2);
      default: return md == mN;
    endcase
  endfunction

  function automatic string mode_tag(input int m);
    case (m)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag);
    int ec;
    bit eo;
    string t;
    t = (tag == "") ? mode_tag(mmode) : tag;
    ec = exp_count();
    eo = exp_out();
    total++;
    if (count_o !== ec[W-1:0]) begin
      bad++;
      $display("FAIL %s count actual=%h expected=%h", t, count_o, ec[W-1:0]);
    end
    total++;
    if (out_o !== eo) begin
      bad++;
      $display("FAIL %s out actual=%b expected=%b", t, out_o, eo);
    end
  endtask

  // drive one cycle at the falling edge, advance the model, check at the next falling edge
  task automatic step(input string tag, input bit ld, input int val, input int mode,
                      input bit bcd, input bit tk, input bit g);
    bit rise;
    load_i = ld; init_i = val[W-1:0]; mode_i = mode[2:0]; bcd_i = bcd;
    tick_en_i = tk; gate_i = g;
    rise = g & ~gprev;
    if (ld) begin
      mmode = fold(mode); mbcd = bcd; md = 0; marmed = 1;
      if (val == 0) mN = bcd ? 10000 : 65536;
      else mN = bcd ? from_bcd(val) : val;
    end else if (marmed) begin
      if (rise && (mmode == 1 || mmode == 2 || mmode == 3 || mmode == 5)) md = 0;
      else if (tk && (g || !(mmode == 0 || mmode == 4))) md++;
    end
    gprev = g;
    @(negedge clk);
    check(tag);
  endtask

  task automatic run(input string tag, input int n, input bit tk, input bit g);
    for (int i = 0; i < n; i++) step(tag, 0, 16'h5A5A, 7, 1, tk, g);
  endtask

  task automatic run_random(input int n);
    bit g;
    g = 1;
    for (int i = 0; i < n; i++) begin
      bit ld, b, tk;
      int mr, v;
      ld = (i == 0) || ($urandom_range(0, 39) == 0);
      mr = $urandom_range(0, 7);
      b  = $urandom_range(0, 1);
      v  = ($urandom_range(0, 9) == 0) ? $urandom_range(0, 9999) : $urandom_range(0, 30);
      if (b) v = to_bcd(v);
      else if ($urandom_range(0, 19) == 0) v = $urandom_range(0, 65535);
      tk = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 7) == 0) g = ~g;
      step("", ld, v, mr, b, tk, g);
    end
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R14 watchdog actual=hung expected=complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1C0DE5));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1");
    // R1: ticks and gate toggles before any load
    run("R1", 3, 1, 1);
    run("R1", 2, 1, 0);
    run("R1", 2, 1, 1);

    // R14 / R4: mode 0, binary, N=5
    step("R14", 1, 5, 0, 0, 1, 1);
    run("R4", 8, 1, 1);
    // R11: binary wrap after terminal
    step("R14", 1, 3, 0, 0, 1, 1);
    run("R4", 3, 1, 1);
    run("R11", 3, 1, 1);

    // R9: mode 0 and 4 with gate low
    step("R9", 1, 6, 0, 0, 1, 1);
    run("R9", 2, 1, 1);
    run("R9", 4, 1, 0);
    run("R9", 5, 1, 1);
    step("R9", 1, 3, 4, 0, 1, 1);
    run("R9", 3, 1, 0);
    run("R8", 5, 1, 1);

    // R5 / R10: mode 1 retrigger
    step("R5", 1, 4, 1, 0, 1, 1);
    run("R5", 6, 1, 1);
    run("R5", 1, 1, 0);
    step("R10", 0, 0, 0, 0, 1, 1);
    run("R5", 6, 1, 1);

    // R6: mode 2, every tick and every other tick
    step("R6", 1, 3, 2, 0, 1, 1);
    run("R6", 10, 1, 1);
    for (int i = 0; i < 8; i++) step("R6", 0, 0, 0, 0, i % 2, 1);
    run("R6", 1, 1, 0);
    step("R10", 0, 0, 0, 0, 1, 1);
    run("R6", 4, 1, 1);

    // R7: mode 3, odd, even and unit counts
    step("R7", 1, 5, 3, 0, 1, 1);
    run("R7", 12, 1, 1);
    step("R7", 1, 4, 3, 0, 1, 1);
    run("R7", 10, 1, 1);
    step("R7", 1, 1, 3, 0, 1, 1);
    run("R7", 4, 1, 1);

    // R8: mode 4 once, mode 5 with retrigger
    step("R8", 1, 3, 4, 0, 1, 1);
    run("R8", 8, 1, 1);
    step("R8", 1, 2, 5, 0, 1, 1);
    run("R8", 5, 1, 1);
    run("R8", 1, 1, 0);
    step("R10", 0, 0, 0, 0, 1, 1);
    run("R8", 4, 1, 1);

    // R13: folded codes and inputs ignored without the strobe
    step("R13", 1, 3, 6, 0, 1, 1);
    for (int i = 0; i < 8; i++) step("R13", 0, i * 7, i % 6, i % 2, 1, 1);
    step("R13", 1, 4, 7, 0, 1, 1);
    run("R13", 9, 1, 1);

    // R12: decimal borrow and R11 decimal wrap
    step("R12", 1, 16'h0012, 0, 1, 1, 1);
    run("R12", 12, 1, 1);
    run("R11", 3, 1, 1);
    step("R12", 1, 16'h0100, 2, 1, 1, 1);
    run("R12", 105, 1, 1);

    // R2 / R3: full counts
    step("R2", 1, 0, 0, 0, 1, 1);
    run("R2", 65537, 1, 1);
    step("R2", 1, 0, 3, 1, 1, 1);
    run("R2", 10003, 1, 1);
    step("R3", 1, 0, 2, 1, 1, 1);
    run("R3", 10003, 1, 1);

    run_random(3000);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule